// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 26-bit physical address by following a two-level page table kept in main memory. A caller presents a virtual address together with the byte address of a root table. The walker then makes two dependent word reads on a memory port. The first read selects a second-level table. The second read fetches the leaf entry. The caller gets back either the physical address along with the leaf's control bits, or a page fault that names the level at which the walk stopped.

The virtual address is split into three fields. Bits [31:22] index the root table. Bits [21:12] index the second-level table. Bits [11:0] are the page offset, which passes through unchanged. Every table entry is one 32-bit word, so an index is multiplied by four to form a byte offset, and a table of 1024 entries fills exactly one 4 KB page.

The walker handles one translation at a time. It tolerates any stall on the request side of the memory port and any latency on the response side.

Top module: `pt_walker`

## Requirements
- R1: The first memory read goes to byte address `root + 4*vaddr[31:22]`.
- R2: If the first-level entry is valid, the second read goes to byte address `{entry1[31:12], 12'h000} + 4*vaddr[21:12]`. In this computation, bits [11:0] of the first-level entry are ignored.
- R3: A valid leaf entry gives a response with `rsp_fault`=0 and the following fields:
  - `rsp_paddr = {leaf[25:12], vaddr[11:0]}`
  - `rsp_dirty = leaf[1]`
  - `rsp_perm = leaf[5:2]`
- R4: A first-level entry with bit 0 (valid) clear ends the walk after one read. The response has `rsp_fault`=1, `rsp_fault_level`=0, and `rsp_paddr`, `rsp_dirty` and `rsp_perm` all zero. No second read is issued.
- R5: A leaf entry with bit 0 clear ends the walk with `rsp_fault`=1, `rsp_fault_level`=1, and `rsp_paddr`, `rsp_dirty` and `rsp_perm` all zero.
- R6: `req_ready` is high only while the walker is idle. `busy` is high from the cycle after a request is accepted up to and including the response cycle. While `busy` is high, `req_ready` is low.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and `mem_req_addr` holds its value. The walk completes correctly for any number of wait cycles on either side of the memory port.
- R8: `rsp_valid` is high for exactly one cycle per accepted request.
- R9: After a synchronous reset, the walker is idle: `req_ready`=1, `busy`=0, `mem_req_valid`=0, `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Byte address of the root table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data word |
| rsp_valid | output | 1 | Translation result, one-cycle pulse |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_fault_level | output | 1 | Level that faulted: 0 first, 1 second |
| rsp_paddr | output | 26 | Physical address |
| rsp_dirty | output | 1 | Dirty bit of the leaf |
| rsp_perm | output | 4 | Access-control bits of the leaf |

## Verification
The bench covers several boundary cases:
- **Highest and lowest index values.** Indices of 0 and 1023, and an offset of 0xFFF. A wrong shift or field slice would send a read to the wrong word or corrupt the offset.
- **Invalid first-level entry.** A walker that ignored the valid bit would issue a stray second read, which the scoreboard reports as unexpected.
- **Invalid leaf whose other bits are all set.** A design that forwarded the leaf fields on a fault would show a nonzero physical address.
- **Second root table pointing into a different second-level table.** This shows that the base is taken from the first-level entry rather than reused.

Every walk is repeated under three memory behaviours: an always-ready port, a toggling ready, and sparse ready with multi-cycle latency. A design that moved its request address during a stall, or sampled the response too early, would read the wrong word.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_REQ  = 2'd1,
    W_WAIT = 2'd2,
    W_DONE = 2'd3
  } walk_state_t;

  localparam int ENT_SHIFT = 2;  // 4-byte entries
  localparam int LEVELS    = 2;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int OFS_W = IDX_W + SHIFT;
  logic [OFS_W-1:0] byte_ofs;

  assign byte_ofs = {idx, {SHIFT{1'b0}}};
  assign addr     = base + ADDR_W'(byte_ofs);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 12,
  parameter int RPN_W  = 14,
  parameter int PERM_W = 4
) (
  input  logic [DATA_W-1:0] entry,
  output logic              valid,
  output logic              dirty,
  output logic [PERM_W-1:0] perm,
  output logic [RPN_W-1:0]  rpn,
  output logic [DATA_W-1:0] next_base
);
  localparam logic [DATA_W-1:0] BASE_MASK = {{(DATA_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  assign valid     = entry[0];
  assign dirty     = entry[1];
  assign perm      = entry[2 +: PERM_W];
  assign rpn       = entry[OFF_W +: RPN_W];
  assign next_base = entry & BASE_MASK;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 26,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int ADDR_W = 32,
  parameter int PERM_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ADDR_W-1:0] req_root,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_fault_level,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_dirty,
  output logic [PERM_W-1:0] rsp_perm
);
  import ptw_pkg::*;

  localparam int RPN_W = PA_W - OFF_W;
  localparam int KEEP_W = OFF_W + IDX_W;  // low part of VA kept for level 2

  walk_state_t       state;
  logic              lvl;
  logic [KEEP_W-1:0] vaddr_q;

  logic              pte_valid, pte_dirty;
  logic [PERM_W-1:0] pte_perm;
  logic [RPN_W-1:0]  pte_rpn;
  logic [ADDR_W-1:0] pte_next_base;

  logic [ADDR_W-1:0] lvl_base [LEVELS];
  logic [IDX_W-1:0]  lvl_idx  [LEVELS];
  logic [ADDR_W-1:0] lvl_addr [LEVELS];

  assign lvl_base[0] = req_root;
  assign lvl_idx[0]  = req_vaddr[VA_W-1 -: IDX_W];
  assign lvl_base[1] = pte_next_base;
  assign lvl_idx[1]  = vaddr_q[OFF_W +: IDX_W];

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    ptw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT(ENT_SHIFT)) u_addr (
      .base(lvl_base[g]),
      .idx (lvl_idx[g]),
      .addr(lvl_addr[g])
    );
  end

  ptw_pte_decode #(.DATA_W(ADDR_W), .OFF_W(OFF_W), .RPN_W(RPN_W), .PERM_W(PERM_W)) u_dec (
    .entry    (mem_rsp_data),
    .valid    (pte_valid),
    .dirty    (pte_dirty),
    .perm     (pte_perm),
    .rpn      (pte_rpn),
    .next_base(pte_next_base)
  );

  assign req_ready     = (state == W_IDLE);
  assign busy          = (state != W_IDLE);
  assign mem_req_valid = (state == W_REQ);
  assign rsp_valid     = (state == W_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= W_IDLE;
      lvl             <= 1'b0;
      vaddr_q         <= '0;
      mem_req_addr    <= '0;
      rsp_fault       <= 1'b0;
      rsp_fault_level <= 1'b0;
      rsp_paddr       <= '0;
      rsp_dirty       <= 1'b0;
      rsp_perm        <= '0;
    end else begin
      case (state)
        W_IDLE: if (req_valid) begin
          vaddr_q      <= req_vaddr[KEEP_W-1:0];
          mem_req_addr <= lvl_addr[0];
          lvl          <= 1'b0;
          state        <= W_REQ;
        end
        W_REQ: if (mem_req_ready) state <= W_WAIT;
        W_WAIT: if (mem_rsp_valid) begin
          if (!pte_valid) begin
            rsp_fault       <= 1'b1;
            rsp_fault_level <= lvl;
            rsp_paddr       <= '0;
            rsp_dirty       <= 1'b0;
            rsp_perm        <= '0;
            state           <= W_DONE;
          end else if (!lvl) begin
            mem_req_addr <= lvl_addr[1];
            lvl          <= 1'b1;
            state        <= W_REQ;
          end else begin
            rsp_fault       <= 1'b0;
            rsp_fault_level <= 1'b0;
            rsp_paddr       <= {pte_rpn, vaddr_q[OFF_W-1:0]};
            rsp_dirty       <= pte_dirty;
            rsp_perm        <= pte_perm;
            state           <= W_DONE;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  // Memory request held steady while stalled
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // Response is a single-cycle pulse
  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // Busy through the response cycle, no acceptance meanwhile
  assert_busy_rsp_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> busy && !req_ready);

  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> busy && !rsp_valid);

  // A fault carries no physical address
  assert_fault_nopa_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_paddr == '0 && !rsp_dirty);

  // Offset passes through on success
  assert_offset_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        rst;
  logic        req_valid, req_ready, busy;
  logic [31:0] req_vaddr, req_root;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic        rsp_valid, rsp_fault, rsp_fault_level, rsp_dirty;
  logic [25:0] rsp_paddr;
  logic [3:0]  rsp_perm;

  pt_walker dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level),
    .rsp_paddr(rsp_paddr), .rsp_dirty(rsp_dirty), .rsp_perm(rsp_perm)
  );

  typedef struct {
    logic        fault;
    logic        level;
    logic [25:0] paddr;
    logic        dirty;
    logic [3:0]  perm;
  } exp_rsp_t;

  logic [31:0] mem [0:4095];
  logic [31:0] exp_addr_q [$];
  bit          exp_lvl_q  [$];
  exp_rsp_t    exp_rsp_q  [$];

  int checks = 0, errors = 0;
  int ready_mode = 0, lat = 0, cyc = 0;
  bit pend = 0, prev_stall = 0, prev_rsp = 0, got_rsp = 0, finished = 0;
  int cnt = 0;
  logic [31:0] pend_addr = '0, prev_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_leaf(logic [13:0] rpn, logic [3:0] perm, bit dirty, bit v);
    return {6'h00, rpn, 6'h00, perm, dirty, v};
  endfunction

  // Memory model and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem[pend_addr[13:2]];
        pend = 0;
      end else cnt--;
    end
    if (!rst) begin
      case (ready_mode)
        0: mem_req_ready = 1'b1;
        1: mem_req_ready = ~mem_req_ready;
        default: mem_req_ready = (cyc % 3 == 0);
      endcase
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R7", "stalled request moved",
            mem_req_addr, prev_addr);
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (exp_addr_q.size() == 0)
          chk(1'b0, "R4", "unexpected memory read", mem_req_addr, 32'h0);
        else begin
          logic [31:0] ea;
          bit el;
          ea = exp_addr_q.pop_front();
          el = exp_lvl_q.pop_front();
          chk(mem_req_addr == ea, el ? "R2" : "R1", "read address", mem_req_addr, ea);
        end
        pend = 1; cnt = lat; pend_addr = mem_req_addr;
      end
      if (prev_rsp) chk(!rsp_valid, "R8", "response longer than one cycle", 32'(rsp_valid), 0);
      prev_rsp = rsp_valid;
      if (rsp_valid) begin
        if (exp_rsp_q.size() == 0) chk(1'b0, "R8", "extra response", 1, 0);
        else begin
          exp_rsp_t e;
          string tag;
          e = exp_rsp_q.pop_front();
          tag = !e.fault ? "R3" : (e.level ? "R5" : "R4");
          chk(rsp_fault == e.fault, tag, "fault", 32'(rsp_fault), 32'(e.fault));
          if (e.fault) chk(rsp_fault_level == e.level, tag, "fault level",
                           32'(rsp_fault_level), 32'(e.level));
          chk(rsp_paddr == e.paddr, tag, "paddr", 32'(rsp_paddr), 32'(e.paddr));
          chk(rsp_dirty == e.dirty && rsp_perm == e.perm, tag, "dirty/perm",
              {27'h0, rsp_dirty, rsp_perm}, {27'h0, e.dirty, e.perm});
          chk(busy && !req_ready, "R6", "busy during response", 32'(busy), 1);
        end
        got_rsp = 1;
      end
    end
  end

  // Watchdog
  always @(negedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] root);
    logic [31:0] a1, a2, e1, e2;
    exp_rsp_t e;
    a1 = root + {20'h0, va[31:22], 2'b00};
    e1 = mem[a1[13:2]];
    exp_addr_q.push_back(a1); exp_lvl_q.push_back(1'b0);
    e = '{fault: 1'b1, level: 1'b0, paddr: '0, dirty: 1'b0, perm: '0};
    if (e1[0]) begin
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      e2 = mem[a2[13:2]];
      exp_addr_q.push_back(a2); exp_lvl_q.push_back(1'b1);
      if (e2[0]) e = '{fault: 1'b0, level: 1'b0, paddr: {e2[25:12], va[11:0]},
                       dirty: e2[1], perm: e2[5:2]};
      else e.level = 1'b1;
    end
    exp_rsp_q.push_back(e);
    @(negedge clk);
    chk(req_ready && !busy, "R6", "idle before request", 32'(req_ready), 1);
    req_vaddr = va; req_root = root; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(busy && !req_ready, "R6", "busy after accept", 32'(busy), 1);
    wait (got_rsp);
    got_rsp = 0;
    chk(exp_addr_q.size() == 0, e.fault ? "R4" : "R2", "reads outstanding",
        exp_addr_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[1]            = 32'h0000_1001;  // root0[1] -> table at 0x1000, low junk ignored
    mem[1] [7:4]      = 4'hE;
    mem[2]            = 32'h0000_1000;  // root0[2] invalid
    mem[12'hC00+1023] = 32'h0000_2001;  // root at 0x3000, [1023] -> 0x2000
    mem[12'h400+5]    = mk_leaf(14'h2A5F, 4'hA, 1'b1, 1'b1);
    mem[12'h400+1023] = mk_leaf(14'h0123, 4'h3, 1'b0, 1'b1);
    mem[12'h400+7]    = 32'hFFFF_FFFE;  // invalid leaf, other bits set
    mem[12'h800+0]    = mk_leaf(14'h3FFF, 4'h5, 1'b0, 1'b1);

    req_valid = 0; req_vaddr = '0; req_root = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    rst = 1;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(req_ready && !busy && !mem_req_valid && !rsp_valid, "R9", "reset state",
        {req_ready, busy, mem_req_valid, rsp_valid}, 4'b1000);

    for (int m = 0; m < 3; m++) begin
      ready_mode = m;
      lat = (m == 2) ? 4 : m;
      walk({10'd1, 10'd5, 12'hABC}, 32'h0000_0000);      // R3 basic
      walk({10'd1, 10'd1023, 12'hFFF}, 32'h0000_0000);   // R1/R2 top index, full offset
      walk({10'd2, 10'd3, 12'h123}, 32'h0000_0000);      // R4 level-1 fault
      walk({10'd1, 10'd7, 12'h456}, 32'h0000_0000);      // R5 leaf fault
      walk({10'd1023, 10'd0, 12'h000}, 32'h0000_3000);   // second root, index 0
      walk({10'd0, 10'd0, 12'h001}, 32'h0000_0000);      // empty root slot
    end

    repeat (5) @(negedge clk);
    chk(exp_rsp_q.size() == 0, "R8", "responses missing", exp_rsp_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule